// File: doc/BRIEF.md
# Reloadable Down-Counting Programmable Timer

This block is an 8-bit down-counter that sits on the 4-bit data bus of a small microcontroller. It counts on one of two count clocks. The first is a square wave divided down from the system clock. The second is an external event pin, which is synchronized into the system clock domain. Every count-clock edge becomes a one-cycle tick, so the whole block runs on a single system clock.

When the counter counts down past zero, it reloads from an 8-bit reload register and sets a sticky interrupt flag. It also toggles an output pin, and a control bit can gate that pin off.

Software starts and stops the counter through a run bit. The run bit does not act on the bus write. The request is synchronized into the timer side and is applied only on the next falling edge of the count clock. The stop edge still decrements the counter once more, and the run bit reads back as 1 until the stop has really happened.

The counter is read as two nibbles. Reading the low nibble captures the high nibble, so a later high-nibble read matches the low nibble that was read earlier.

Top module: `dntimer`

## Requirements
- R1: After reset the counter is 00h, the run readback is 0, the interrupt flag is 0 and the output pin is 0.
- R2: The counter changes only on a falling or a rising count-clock edge. Without such edges it holds its value, even across many system clock cycles.
- R3: A write to the run bit (bit 0 of the control register at address 4) takes effect at the next falling edge of the count clock. The edge that starts the timer does not decrement the counter.
- R4: While the timer runs, each falling edge decrements the counter by one. The falling edge that applies a stop decrements the counter one final time, and later edges leave it unchanged.
- R5: The run readback is 1 from a write of 1 until a stop has taken effect on a falling edge. In event mode with no incoming edge, it stays 1 after a stop is written.
- R6: A falling edge that finds the counter at 00h while the timer runs is an underflow. It loads the reload register (low nibble at address 2, high nibble at address 3). The value in the reload register at the following rising edge is the value the counter finally keeps.
- R7: An underflow sets the interrupt flag (bit 0 at address 5, also driven on `irq_flag`). The flag is cleared only by writing 1 to that bit. Writing 0 has no effect.
- R8: The output state toggles on every underflow. The `tout` pin equals that state ANDed with the output-enable bit (bit 2 of the control register).
- R9: Reading address 0 returns the low nibble of the counter and captures its high nibble. Reading address 1 returns the captured high nibble.
- R10: Control bit 1 selects the count clock: 1 selects the `evt_in` pin, 0 selects the internal divider, which has a period of 2*PRE_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; a read of address 0 captures the high nibble |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data for the addressed register |
| evt_in | input | 1 | External event count clock |
| tout | output | 1 | Timer output, gated by output enable |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The hardest case to reach is the window between an underflow's falling edge and the next rising edge, where a reload write can still change the committed value. The bench drives the event pin by hand, one half-period at a time. It first brings the counter to 00h, then applies only the falling half. Next it rewrites the reload register and applies only the rising half, so it can observe the pre-commit value and the committed value separately. A stop written while no event edge arrives is held for many cycles, to show that the run readback stays high and the counter holds.

// File: rtl/dntm_pkg.sv
package dntm_pkg;
  localparam int CNT_W  = 8;
  localparam int NIB_W  = 4;
  localparam int ADDR_W = 3;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [NIB_W-1:0] nib_t;

  typedef enum logic [ADDR_W-1:0] {
    A_CNT_LO = 3'd0,
    A_CNT_HI = 3'd1,
    A_RLD_LO = 3'd2,
    A_RLD_HI = 3'd3,
    A_CTRL   = 3'd4,
    A_FLAG   = 3'd5
  } addr_e;

  localparam int CTL_RUN = 0;
  localparam int CTL_EVT = 1;
  localparam int CTL_OE  = 2;

  // Underflow happens when a running counter is stepped from zero.
  function automatic logic is_underflow(cnt_t c);
    return c == '0;
  endfunction

  // Next counter value on a running falling edge.
  function automatic cnt_t step_down(cnt_t c, cnt_t rld);
    return is_underflow(c) ? rld : cnt_t'(c - 1'b1);
  endfunction
endpackage

// File: rtl/dntm_clksel.sv
module dntm_clksel #(
  parameter int PRE_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic use_evt,
  input  logic evt_in,
  output logic fall_tick,
  output logic rise_tick
);
  localparam int PW = $clog2(PRE_DIV + 1);

  logic [PW-1:0]          pre_cnt;
  logic                   pre_lvl;
  logic [SYNC_STAGES-1:0] evt_sync;
  logic                   sel_lvl;
  logic                   lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      pre_lvl <= 1'b0;
    end else if (pre_cnt == PW'(PRE_DIV - 1)) begin
      pre_cnt <= '0;
      pre_lvl <= ~pre_lvl;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_sync <= '0;
        else        evt_sync <= evt_in;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_sync <= '0;
        else        evt_sync <= {evt_sync[SYNC_STAGES-2:0], evt_in};
      end
    end
  endgenerate

  assign sel_lvl = use_evt ? evt_sync[SYNC_STAGES-1] : pre_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= sel_lvl;
  end

  assign fall_tick = lvl_q & ~sel_lvl;
  assign rise_tick = ~lvl_q & sel_lvl;
endmodule

// File: rtl/dntm_core.sv
module dntm_core
  import dntm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_tick,
  input  logic rise_tick,
  input  logic run_req,
  input  cnt_t rld,
  output cnt_t cnt_q,
  output logic run_act,
  output logic uf_evt,
  output logic tout_q
);
  logic [SYNC_STAGES-1:0] req_sync;
  logic                   run_req_s;
  logic                   pend_q;

  generate
    if (SYNC_STAGES == 1) begin : g_rs1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_sync <= '0;
        else        req_sync <= run_req;
      end
    end else begin : g_rsn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_sync <= '0;
        else        req_sync <= {req_sync[SYNC_STAGES-2:0], run_req};
      end
    end
  endgenerate
  assign run_req_s = req_sync[SYNC_STAGES-1];

  assign uf_evt = fall_tick & run_act & is_underflow(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      run_act <= 1'b0;
      pend_q  <= 1'b0;
      tout_q  <= 1'b0;
    end else if (fall_tick) begin
      run_act <= run_req_s;
      pend_q  <= uf_evt;
      if (run_act) cnt_q <= step_down(cnt_q, rld);
      if (uf_evt)  tout_q <= ~tout_q;
    end else if (rise_tick && pend_q) begin
      cnt_q  <= rld;
      pend_q <= 1'b0;
    end
  end

  AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_tick && !rise_tick) |=> $stable(cnt_q)); // R2
  AST_RUN_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_tick |=> $stable(run_act)); // R3
  AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_tick && run_act && cnt_q != '0) |=> cnt_q == cnt_t'($past(cnt_q) - 1'b1)); // R4
  AST_RELOAD_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_tick && pend_q && !fall_tick) |=> cnt_q == $past(rld)); // R6
  AST_TOUT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt |=> tout_q != $past(tout_q)); // R8
endmodule

// File: rtl/dntm_regs.sv
module dntm_regs
  import dntm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  nib_t              bus_wdata,
  output nib_t              bus_rdata,
  input  cnt_t              cnt_q,
  input  logic              run_act,
  input  logic              uf_evt,
  output logic              run_req,
  output logic              use_evt,
  output logic              oe,
  output cnt_t              rld,
  output logic              flag_q
);
  logic [SYNC_STAGES-1:0] act_sync;
  logic                   run_rb;
  nib_t                   hi_hold;
  logic                   wr_ctrl, wr_flag_clr;

  assign wr_ctrl     = bus_we && (bus_addr == A_CTRL);
  assign wr_flag_clr = bus_we && (bus_addr == A_FLAG) && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_req <= 1'b0;
      use_evt <= 1'b0;
      oe      <= 1'b0;
      rld     <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_RLD_LO: rld[NIB_W-1:0]     <= bus_wdata;
        A_RLD_HI: rld[CNT_W-1:NIB_W] <= bus_wdata;
        A_CTRL: begin
          run_req <= bus_wdata[CTL_RUN];
          use_evt <= bus_wdata[CTL_EVT];
          oe      <= bus_wdata[CTL_OE];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           flag_q <= 1'b0;
    else if (uf_evt)      flag_q <= 1'b1;
    else if (wr_flag_clr) flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_hold <= '0;
    else if (bus_re && bus_addr == A_CNT_LO) hi_hold <= cnt_q[CNT_W-1:NIB_W];
  end

  generate
    if (SYNC_STAGES == 1) begin : g_as1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_sync <= '0;
        else        act_sync <= run_act;
      end
    end else begin : g_asn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_sync <= '0;
        else        act_sync <= {act_sync[SYNC_STAGES-2:0], run_act};
      end
    end
  endgenerate

  assign run_rb = run_req | act_sync[SYNC_STAGES-1];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CNT_LO: bus_rdata = cnt_q[NIB_W-1:0];
      A_CNT_HI: bus_rdata = hi_hold;
      A_RLD_LO: bus_rdata = rld[NIB_W-1:0];
      A_RLD_HI: bus_rdata = rld[CNT_W-1:NIB_W];
      A_CTRL:   bus_rdata = {1'b0, oe, use_evt, run_rb};
      A_FLAG:   bus_rdata = {3'b000, flag_q};
      default:  bus_rdata = '0;
    endcase
  end

  AST_UF_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt |=> flag_q); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !wr_flag_clr) |=> flag_q); // R7
endmodule

// File: rtl/dntimer.sv
module dntimer
  import dntm_pkg::*;
#(
  parameter int PRE_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [NIB_W-1:0]  bus_wdata,
  output logic [NIB_W-1:0]  bus_rdata,
  input  logic              evt_in,
  output logic              tout,
  output logic              irq_flag
);
  logic fall_tick, rise_tick;
  logic run_req, use_evt, oe, run_act, uf_evt, tout_q, flag_q;
  cnt_t cnt_q, rld;

  dntm_clksel #(.PRE_DIV(PRE_DIV), .SYNC_STAGES(SYNC_STAGES)) u_clk (
    .clk(clk), .rst_n(rst_n), .use_evt(use_evt), .evt_in(evt_in),
    .fall_tick(fall_tick), .rise_tick(rise_tick)
  );

  dntm_core #(.SYNC_STAGES(SYNC_STAGES)) u_core (
    .clk(clk), .rst_n(rst_n), .fall_tick(fall_tick), .rise_tick(rise_tick),
    .run_req(run_req), .rld(rld), .cnt_q(cnt_q), .run_act(run_act),
    .uf_evt(uf_evt), .tout_q(tout_q)
  );

  dntm_regs #(.SYNC_STAGES(SYNC_STAGES)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_q(cnt_q), .run_act(run_act), .uf_evt(uf_evt),
    .run_req(run_req), .use_evt(use_evt), .oe(oe), .rld(rld), .flag_q(flag_q)
  );

  assign tout     = tout_q & oe;
  assign irq_flag = flag_q;

  AST_TOUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !tout); // R8
endmodule

// File: tb/dntimer_test.sv
module dntimer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_we = 1'b0, bus_re = 1'b0;
  logic [3:0] bus_wdata = '0;
  logic [3:0] bus_rdata;
  logic       evt_in = 1'b0;
  logic       tout, irq_flag;
  int         n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  dntimer uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_in(evt_in), .tout(tout), .irq_flag(irq_flag)
  );

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [3:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [3:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_re = 1'b0;
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic evt_rise(); evt_in = 1'b1; wait_clk(6); endtask
  task automatic evt_fall(); evt_in = 1'b0; wait_clk(6); endtask
  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin evt_rise(); evt_fall(); end
  endtask

  task automatic rd_cnt(output logic [7:0] c);
    logic [3:0] lo, hi;
    rd(3'd0, lo); rd(3'd1, hi); c = {hi, lo};
  endtask

  task automatic t_reset();
    logic [7:0] c; logic [3:0] d;
    rd_cnt(c);     chk("R1 count", c, 8'h00);
    rd(3'd4, d);   chk("R1 run readback", d[0], 0);
    chk("R1 flag", irq_flag, 0);
    chk("R1 tout", tout, 0);
  endtask

  task automatic t_start_underflow();
    logic [7:0] c; logic [3:0] d;
    wr(3'd2, 4'h5); wr(3'd3, 4'h2);
    wr(3'd4, 4'b0111);
    rd(3'd4, d);   chk("R5 readback after run write", d[0], 1);
    wait_clk(20);
    rd_cnt(c);     chk("R2 hold without edge", c, 8'h00);
    pulse(1);
    rd_cnt(c);     chk("R3 start edge no decrement", c, 8'h00);
    chk("R7 no flag before underflow", irq_flag, 0);
    pulse(1);
    rd_cnt(c);     chk("R6 reload on underflow", c, 8'h25);
    chk("R7 flag set on underflow", irq_flag, 1);
    chk("R8 tout toggled", tout, 1);
    wr(3'd4, 4'b0011);
    chk("R8 tout gated off", tout, 0);
    wr(3'd4, 4'b0111);
    chk("R8 tout gated on", tout, 1);
    pulse(1);
    rd_cnt(c);     chk("R4 decrement after reload", c, 8'h24);
  endtask

  task automatic t_flag();
    logic [3:0] d;
    wr(3'd5, 4'h0);
    rd(3'd5, d);   chk("R7 write 0 keeps flag", d[0], 1);
    wr(3'd5, 4'h1);
    rd(3'd5, d);   chk("R7 write 1 clears flag", d[0], 0);
    chk("R7 irq pin cleared", irq_flag, 0);
  endtask

  task automatic t_nibble();
    logic [3:0] d;
    rd(3'd0, d);   chk("R9 low nibble", d, 4'h4);
    pulse(5);
    rd(3'd1, d);   chk("R9 captured high nibble", d, 4'h2);
    rd(3'd0, d);   chk("R9 new low nibble", d, 4'hF);
    rd(3'd1, d);   chk("R9 recaptured high nibble", d, 4'h1);
  endtask

  task automatic t_stop();
    logic [7:0] c; logic [3:0] d;
    wr(3'd4, 4'b0110);
    wait_clk(4);
    rd(3'd4, d);   chk("R5 readback high until stop", d[0], 1);
    wait_clk(40);
    rd(3'd4, d);   chk("R5 no edge keeps readback", d[0], 1);
    rd_cnt(c);     chk("R2 R10 no event edge holds count", c, 8'h1F);
    pulse(1);
    rd_cnt(c);     chk("R4 final decrement on stop", c, 8'h1E);
    wait_clk(4);
    rd(3'd4, d);   chk("R5 readback low after stop", d[0], 0);
    pulse(2);
    rd_cnt(c);     chk("R4 stopped count holds", c, 8'h1E);
  endtask

  task automatic t_reload_window();
    logic [7:0] c;
    wr(3'd2, 4'h2); wr(3'd3, 4'h0);
    wr(3'd4, 4'b0111);
    wait_clk(4);
    pulse(1);
    rd_cnt(c);     chk("R3 restart edge no decrement", c, 8'h1E);
    pulse(30);
    rd_cnt(c);     chk("R4 counted to zero", c, 8'h00);
    pulse(1);
    rd_cnt(c);     chk("R6 value before rising edge", c, 8'h02);
    chk("R8 tout toggled back", tout, 0);
    wr(3'd2, 4'h7);
    evt_rise();
    rd_cnt(c);     chk("R6 late write committed at rise", c, 8'h07);
    evt_fall();
    rd_cnt(c);     chk("R4 decrement from committed value", c, 8'h06);
  endtask

  task automatic t_internal();
    logic [7:0] c; logic [3:0] d;
    wr(3'd5, 4'h1);
    wr(3'd4, 4'b0101);
    wait_clk(300);
    chk("R10 internal clock reaches underflow", irq_flag, 1);
    rd(3'd4, d);   chk("R10 mode bit reads 0", d[1], 0);
    rd_cnt(c);
    chk("R10 count within reload range", (c <= 8'h07) ? 1 : 0, 1);
  endtask

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    t_reset();
    t_start_underflow();
    t_flag();
    t_nibble();
    t_stop();
    t_reload_window();
    t_internal();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule